// File: doc/BRIEF.md
# External Bus Arbitration Controller

This block decides who drives the chip's external memory bus: the on-chip bus master or an outside device. The outside device raises a request. The controller lets the internal access that is already in flight finish, and then raises a grant. While the grant is high, the controller drops the output-enable for the address, chip-select, read and write strobe, RAS and CAS pads, so that those pads float. When the outside device drops its request, the controller lowers the grant and turns the pads back on.

A DRAM refresh that becomes due while the bus is lent out takes priority. The controller lowers the grant at once to ask for the bus back. It keeps the pads floating until it sees the outside device let go, and only then lets the refresh run. A refresh that is pending also holds off any new lending.

Each CPU access port presents a class code with every request. Internal RAM and ROM accesses always get a go. I/O and external-memory accesses get a go only while the chip plainly owns the bus. All state changes happen on the system clock.

Top module: `ext_bus_arbiter`

## Requirements
- R1: The grant rises only on the clock edge that follows a cycle in which `accBusy` is low. While `accBusy` stays high, the grant stays low.
- R2: `extReq` passes through `SYNC_STAGES` flops (default 2). When the bus is idle and no refresh is pending, a request first driven before edge 1 gives grant high from edge 4 on.
- R3: After `extReq` is lowered while the grant is high, the grant falls and `padOe` rises on the third edge.
- R4: If `extReq` is withdrawn while an access is still holding off the handover, the grant never rises and the chip returns to plain ownership.
- R5: `padOe` is high exactly while the chip owns the bus. It is low while the grant is high and while the bus is being reclaimed. `padOe` and the grant are never high together.
- R6: A `refreshReq` pulse during release lowers the grant on the second edge after the pulse. `padOe` then stays low, and `refreshGo` stays low, until the third edge after `extReq` is seen low. On that edge both rise.
- R7: A refresh request stays pending until `refreshDone`, and `refreshGo` is high while it is pending and the chip owns the bus. When `refreshReq` and `refreshDone` are high in the same cycle, the request remains pending.
- R8: While a refresh is pending and the chip owns the bus, a raised `extReq` is not granted. The handover starts after `refreshDone`, and the grant rises on the third edge after it.
- R9: Class codes 0 (internal data RAM) and 1 (internal ROM/flash) receive `cpuGo` in the same cycle they are requested, in every arbitration state.
- R10: Class codes 2 (internal I/O) and 3 (external memory) receive `cpuGo` only in plain ownership. They are held during a pending handover, a release and a reclaim, and a held request gets `cpuGo` on the edge where ownership returns.
- R11: During and right after reset the grant is low, `padOe` is high and `refreshGo` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extReq | input | 1 | Bus request from the external device, asynchronous |
| accBusy | input | 1 | Internal bus access in progress |
| refreshReq | input | 1 | Refresh request pulse from the DRAM controller |
| refreshDone | input | 1 | Refresh completed acknowledge |
| cpuReq | input | NUM_MASTERS | Access request per CPU port |
| cpuClass | input | 2*NUM_MASTERS | Access class per port: 0 RAM, 1 ROM, 2 I/O, 3 external |
| busGrant | output | 1 | High while the bus is lent to the external device |
| padOe | output | 1 | Output-enable for the bus pads |
| refreshGo | output | 1 | Refresh may run now |
| cpuGo | output | NUM_MASTERS | Access may proceed, per port |

## Verification
The properties assume that `refreshDone` arrives only while `refreshGo` is high. They also assume that `accBusy` rises only for an access that was given a go, so it does not start a new access while the bus is lent out. The stimulus keeps to this. It raises `accBusy` only in plain ownership and pulses `refreshDone` only after `refreshGo` has been seen high. It changes the external request only at clock falls, holding each level for several cycles so that the synchronizer never sees a single-cycle glitch.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    ST_OWNED     = 2'd0,
    ST_WAIT_DONE = 2'd1,
    ST_RELEASED  = 2'd2,
    ST_RECLAIM   = 2'd3
  } arbState_t;

  typedef enum logic [1:0] {
    CLS_RAM = 2'd0,
    CLS_ROM = 2'd1,
    CLS_IO  = 2'd2,
    CLS_EXT = 2'd3
  } accClass_t;

  typedef struct packed {
    logic padDrive;     // pads driven by the chip
    logic grantExt;     // bus lent to the external device
    logic extPathOpen;  // I/O and external classes may proceed
    logic refreshOk;    // refresh may use the bus
  } arbStrobe_t;

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqSync,
  input  logic       refPend,
  input  logic       accBusy,
  output arbStrobe_t strobe
);

  arbState_t stateQ, stateNext;

  always_comb begin
    stateNext = stateQ;
    unique case (stateQ)
      ST_OWNED: begin
        if (reqSync && !refPend) stateNext = ST_WAIT_DONE;
      end
      ST_WAIT_DONE: begin
        if (!reqSync || refPend) stateNext = ST_OWNED;
        else if (!accBusy)       stateNext = ST_RELEASED;
      end
      ST_RELEASED: begin
        if (!reqSync)     stateNext = ST_OWNED;
        else if (refPend) stateNext = ST_RECLAIM;
      end
      ST_RECLAIM: begin
        if (!reqSync) stateNext = ST_OWNED;
      end
      default: stateNext = ST_OWNED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_OWNED;
    else       stateQ <= stateNext;
  end

  always_comb begin
    strobe.padDrive    = (stateQ == ST_OWNED) || (stateQ == ST_WAIT_DONE);
    strobe.grantExt    = (stateQ == ST_RELEASED);
    strobe.extPathOpen = (stateQ == ST_OWNED);
    strobe.refreshOk   = (stateQ == ST_OWNED);
  end

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_MASTERS = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     extReq,
  input  logic                     refreshReq,
  input  logic                     refreshDone,
  input  logic [NUM_MASTERS-1:0]   cpuReq,
  input  logic [2*NUM_MASTERS-1:0] cpuClass,
  input  arbStrobe_t               strobe,
  output logic                     reqSync,
  output logic                     refPend,
  output logic                     busGrant,
  output logic                     padOe,
  output logic                     refreshGo,
  output logic [NUM_MASTERS-1:0]   cpuGo
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[LAST_STAGE-1:0], extReq};
  end

  assign reqSync = syncQ[LAST_STAGE];

  // A new request wins over a simultaneous acknowledge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refPend <= 1'b0;
    else       refPend <= refreshReq || (refPend && !refreshDone);
  end

  assign busGrant  = strobe.grantExt;
  assign padOe     = strobe.padDrive;
  assign refreshGo = refPend && strobe.refreshOk;

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_master
    accClass_t cls;
    logic      internalCls;
    assign cls         = accClass_t'(cpuClass[2*m +: 2]);
    assign internalCls = (cls == CLS_RAM) || (cls == CLS_ROM);
    assign cpuGo[m]    = cpuReq[m] && (internalCls || strobe.extPathOpen);
  end

endmodule

// File: rtl/ext_bus_arbiter.sv
module ext_bus_arbiter
  import arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_MASTERS = 2,
  parameter int MCLK_RATIO  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     extReq,
  input  logic                     accBusy,
  input  logic                     refreshReq,
  input  logic                     refreshDone,
  input  logic [NUM_MASTERS-1:0]   cpuReq,
  input  logic [2*NUM_MASTERS-1:0] cpuClass,
  output logic                     busGrant,
  output logic                     padOe,
  output logic                     refreshGo,
  output logic [NUM_MASTERS-1:0]   cpuGo
);

  // Pads switch on the same system-clock edge as the grant, which lies inside
  // the allowed early-float window for both supported clock ratios.
  if (!((MCLK_RATIO == 2) || (MCLK_RATIO == 4))) begin : g_bad_ratio
    $error("MCLK_RATIO must be 2 or 4");
  end
  if (SYNC_STAGES < 2) begin : g_bad_sync
    $error("SYNC_STAGES must be at least 2");
  end

  arbStrobe_t strobe;
  logic       reqSync;
  logic       refPend;

  arb_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqSync (reqSync),
    .refPend (refPend),
    .accBusy (accBusy),
    .strobe  (strobe)
  );

  arb_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .NUM_MASTERS (NUM_MASTERS)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .extReq      (extReq),
    .refreshReq  (refreshReq),
    .refreshDone (refreshDone),
    .cpuReq      (cpuReq),
    .cpuClass    (cpuClass),
    .strobe      (strobe),
    .reqSync     (reqSync),
    .refPend     (refPend),
    .busGrant    (busGrant),
    .padOe       (padOe),
    .refreshGo   (refreshGo),
    .cpuGo       (cpuGo)
  );

endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NUM_MASTERS = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     accBusy,
  input logic                     refreshDone,
  input logic [NUM_MASTERS-1:0]   cpuReq,
  input logic [2*NUM_MASTERS-1:0] cpuClass,
  input logic                     busGrant,
  input logic                     padOe,
  input logic                     refreshGo,
  input logic [NUM_MASTERS-1:0]   cpuGo
);

  p_grant_after_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busGrant) |-> $past(!accBusy));

  p_pad_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(busGrant && padOe));

  p_refresh_owned_r7: assert property (@(posedge clk) disable iff (!rstN)
    refreshGo |-> (padOe && !busGrant));

  p_refresh_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (refreshGo && !refreshDone) |=> refreshGo);

  p_no_lend_pending_r8: assert property (@(posedge clk) disable iff (!rstN)
    (refreshGo && !refreshDone) |=> !busGrant);

  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_chk
    p_go_needs_req_r10: assert property (@(posedge clk) disable iff (!rstN)
      cpuGo[m] |-> cpuReq[m]);

    p_internal_go_r9: assert property (@(posedge clk) disable iff (!rstN)
      (cpuReq[m] && !cpuClass[2*m+1]) |-> cpuGo[m]);

    p_ext_stall_r10: assert property (@(posedge clk) disable iff (!rstN)
      (cpuGo[m] && cpuClass[2*m+1]) |-> (padOe && !busGrant));
  end

endmodule

bind ext_bus_arbiter arb_checker #(.NUM_MASTERS(NUM_MASTERS)) i_arb_checker (.*);

// File: tb/test_ext_bus_arbiter.sv
module test_ext_bus_arbiter;

  localparam int NM = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          extReq = 1'b0;
  logic          accBusy = 1'b0;
  logic          refreshReq = 1'b0;
  logic          refreshDone = 1'b0;
  logic [NM-1:0]   cpuReq = '0;
  logic [2*NM-1:0] cpuClass = '0;
  logic          busGrant;
  logic          padOe;
  logic          refreshGo;
  logic [NM-1:0] cpuGo;

  always #2.5 clk = ~clk;

  ext_bus_arbiter #(.SYNC_STAGES(2), .NUM_MASTERS(NM), .MCLK_RATIO(4)) i_ext_bus_arbiter (
    .clk(clk), .rstN(rstN), .extReq(extReq), .accBusy(accBusy),
    .refreshReq(refreshReq), .refreshDone(refreshDone),
    .cpuReq(cpuReq), .cpuClass(cpuClass),
    .busGrant(busGrant), .padOe(padOe), .refreshGo(refreshGo), .cpuGo(cpuGo)
  );

  typedef struct {
    int    due;
    bit    g;
    bit    oe;
    bit    rg;
    bit    own;
    string req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expectAt(int d, bit g, bit oe, bit rg, bit own, string req);
    exp_t e;
    e.due = cyc + d; e.g = g; e.oe = oe; e.rg = rg; e.own = own; e.req = req;
    q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  // Monitor: pops due items and compares them with the outputs.
  always @(negedge clk) begin
    #2;
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.req, "busGrant", int'(busGrant), int'(e.g));
      cmp(e.req, "padOe", int'(padOe), int'(e.oe));
      cmp(e.req, "refreshGo", int'(refreshGo), int'(e.rg));
      for (int m = 0; m < NM; m++) begin
        bit internal;
        bit expGo;
        internal = (cpuClass[2*m +: 2] == 2'd0) || (cpuClass[2*m +: 2] == 2'd1);
        expGo = cpuReq[m] && (internal || e.own);
        cmp(internal ? "R9" : "R10", $sformatf("cpuGo[%0d]", m), int'(cpuGo[m]), int'(expGo));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cpuReq = 2'b11;
    cpuClass = {2'd2, 2'd0};   // port1 I/O, port0 RAM
    tick(3);
    expectAt(0, 0, 1, 0, 1, "R11");
    tick(1);
    rstN = 1'b1;
    expectAt(1, 0, 1, 0, 1, "R11");
    tick(2);

    // Handover held by a busy access (R1), then returned (R3, R10).
    extReq = 1'b1; accBusy = 1'b1;
    expectAt(1, 0, 1, 0, 1, "R1");
    expectAt(2, 0, 1, 0, 1, "R1");
    expectAt(3, 0, 1, 0, 0, "R1");
    tick(3);
    expectAt(1, 0, 1, 0, 0, "R1");
    expectAt(2, 0, 1, 0, 0, "R1");
    tick(2);
    accBusy = 1'b0;
    expectAt(1, 1, 0, 0, 0, "R1");
    tick(1);
    cpuClass = {2'd3, 2'd1};   // port1 external, port0 ROM
    expectAt(0, 1, 0, 0, 0, "R5");
    extReq = 1'b0;
    expectAt(1, 1, 0, 0, 0, "R3");
    expectAt(2, 1, 0, 0, 0, "R3");
    expectAt(3, 0, 1, 0, 1, "R3");
    tick(5);

    // Idle-bus latency (R2), then a refresh during release (R6).
    extReq = 1'b1;
    expectAt(1, 0, 1, 0, 1, "R2");
    expectAt(2, 0, 1, 0, 1, "R2");
    expectAt(3, 0, 1, 0, 0, "R2");
    expectAt(4, 1, 0, 0, 0, "R2");
    tick(4);
    refreshReq = 1'b1;
    expectAt(1, 1, 0, 0, 0, "R6");
    expectAt(2, 0, 0, 0, 0, "R6");
    expectAt(3, 0, 0, 0, 0, "R6");
    expectAt(4, 0, 0, 0, 0, "R6");
    tick(1);
    refreshReq = 1'b0;
    tick(3);
    extReq = 1'b0;
    expectAt(1, 0, 0, 0, 0, "R6");
    expectAt(2, 0, 0, 0, 0, "R6");
    expectAt(3, 0, 1, 1, 1, "R6");
    expectAt(4, 0, 1, 1, 1, "R7");
    tick(4);

    // Pending refresh blocks a new handover (R8).
    extReq = 1'b1;
    for (int d = 1; d <= 6; d++) expectAt(d, 0, 1, 1, 1, "R8");
    tick(6);
    refreshDone = 1'b1;
    expectAt(1, 0, 1, 0, 1, "R8");
    expectAt(2, 0, 1, 0, 0, "R8");
    expectAt(3, 1, 0, 0, 0, "R8");
    tick(1);
    refreshDone = 1'b0;
    tick(2);
    extReq = 1'b0;
    expectAt(3, 0, 1, 0, 1, "R3");
    tick(5);

    // Request withdrawn before the grant (R4).
    cpuClass = {2'd2, 2'd0};
    extReq = 1'b1; accBusy = 1'b1;
    expectAt(1, 0, 1, 0, 1, "R4");
    expectAt(2, 0, 1, 0, 1, "R4");
    expectAt(3, 0, 1, 0, 0, "R4");
    tick(3);
    extReq = 1'b0;
    expectAt(1, 0, 1, 0, 0, "R4");
    expectAt(2, 0, 1, 0, 0, "R4");
    expectAt(3, 0, 1, 0, 1, "R4");
    expectAt(4, 0, 1, 0, 1, "R4");
    tick(4);
    accBusy = 1'b0;
    tick(2);

    // Simultaneous request and acknowledge keeps the refresh pending (R7).
    refreshReq = 1'b1;
    expectAt(1, 0, 1, 1, 1, "R7");
    tick(1);
    refreshDone = 1'b1;
    expectAt(1, 0, 1, 1, 1, "R7");
    tick(1);
    refreshReq = 1'b0; refreshDone = 1'b0;
    expectAt(1, 0, 1, 1, 1, "R7");
    expectAt(2, 0, 1, 1, 1, "R7");
    expectAt(3, 0, 1, 1, 1, "R7");
    tick(3);
    refreshDone = 1'b1;
    expectAt(1, 0, 1, 0, 1, "R7");
    tick(1);
    refreshDone = 1'b0;
    tick(3);

    while (q.size() > 0) tick(1);
    tick(1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule